// File: doc/BRIEF.md
# APB Register-Mapped GPIO Port

This block is a sixteen-pin general-purpose I/O peripheral that answers as an APB subordinate. Software reaches three word-addressed registers: one holds the value each pin should drive, one chooses per pin whether it drives or listens, and one read-only register reports the level currently seen on every pin. A driving pin reports the level it drives; a listening pin reports the level presented on its external input.

Pads are modelled as three separate vectors: an input level, an output value and an output enable. No tristate logic exists inside the block, and the pad ring combines the three signals outside it. Every transfer completes in its access phase with no wait states. An access to an offset that does not exist, or a write to the read-only level register, is answered with an error and changes nothing.

Top module: `gpio_apb_port`

## Requirements
- R1: An active-low reset, applied asynchronously, clears the drive-value and direction registers at once. While it is held and after it is released, `pin_out` and `pin_oe` read zero, so every pin is an input.
- R2: A write to word index 0 (byte address 0x0) stores `pwdata[15:0]` as the drive value and ignores `pwdata[31:16]`. A later read of word index 0 returns the stored value.
- R3: A write to word index 1 (byte address 0x4) stores the direction. A later read of word index 1 returns it. Bit value 1 makes a pin an output, and bit value 0 makes it an input.
- R4: For each pin i, `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals drive-value bit i.
- R5: A read of word index 2 (byte address 0x8) returns, for each pin, the drive-value bit if its direction bit is 1 and `pin_in` if its direction bit is 0.
- R6: A register changes only at a clock edge where `psel`, `penable` and `pwrite` are all high. A setup phase alone (`penable` low) or `penable` with `psel` low changes no register.
- R7: `pready` is always 1, so every transfer completes in its first access cycle.
- R8: `prdata[31:16]` is always zero. `prdata` is zero except during the access phase of a read that does not fail.
- R9: During an access phase, `pslverr` is 1 for a write to word index 2 and for any access to a word index above 2. Such an access changes no register. At all other times `pslverr` is 0.
- R10: The register is chosen by the word index `paddr[31:2]`. Byte-offset bits `paddr[1:0]` are ignored, so byte address 0x5 selects the direction register. Any nonzero upper address bit, for example address 0x100, counts as an index above 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| paddr | input | 32 | Byte address |
| pwdata | input | 32 | Write data |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | Access phase marker |
| prdata | output | 32 | Read data, zero-extended |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response for the access |
| pin_in | input | 16 | Levels sampled from the pads |
| pin_out | output | 16 | Value driven on output pins |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
The two state registers drive the pad outputs directly. A corrupted drive or direction bit therefore shows on `pin_out` or `pin_oe` in the same cycle, long before software reads it back. A wrong decode shows in the access phase itself, as read data from the wrong register or a missing or spurious `pslverr`. A write that lands when it should not shows on the pads one cycle after that access. The level readback is the only path that mixes both registers with `pin_in`, so reads are taken with both all-output and all-input directions and with mixed directions.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;

   // Number of byte-offset bits below the word index.
   localparam int unsigned BYTE_LSB = 2;

   typedef enum logic [1:0] {
      SLOT_DRIVE = 2'd0,
      SLOT_DIR   = 2'd1,
      SLOT_LEVEL = 2'd2,
      SLOT_NONE  = 2'd3
   } slot_e;

   typedef struct packed {
      logic  rd;
      logic  wr;
      logic  err;
      slot_e slot;
   } access_t;

endpackage

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
   import gpio_apb_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] paddr,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   output access_t           acc
);

   localparam int unsigned IDX_W = ADDR_W - BYTE_LSB;

   logic [IDX_W-1:0] word_idx;
   slot_e            slot;
   logic             in_access;
   logic             bad;

   assign word_idx  = paddr[ADDR_W-1:BYTE_LSB];
   assign in_access = psel & penable;

   always_comb begin
      if (word_idx == IDX_W'(0))      slot = SLOT_DRIVE;
      else if (word_idx == IDX_W'(1)) slot = SLOT_DIR;
      else if (word_idx == IDX_W'(2)) slot = SLOT_LEVEL;
      else                            slot = SLOT_NONE;
   end

   assign bad = (slot == SLOT_NONE) | ((slot == SLOT_LEVEL) & pwrite);

   always_comb begin
      acc.slot = slot;
      acc.err  = in_access & bad;
      acc.wr   = in_access & pwrite & ~bad;
      acc.rd   = in_access & ~pwrite & ~bad;
   end

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
   import gpio_apb_pkg::*;
#(
   parameter int unsigned PINS   = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  access_t           acc,
   input  logic [DATA_W-1:0] wdata,
   output logic [PINS-1:0]   drive_q,
   output logic [PINS-1:0]   dir_q
);

   logic wr_drive;
   logic wr_dir;

   assign wr_drive = acc.wr & (acc.slot == SLOT_DRIVE);
   assign wr_dir   = acc.wr & (acc.slot == SLOT_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= '0;
      end else if (wr_drive) begin
         drive_q <= wdata[PINS-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_dir) begin
         dir_q <= wdata[PINS-1:0];
      end
   end

endmodule

// File: rtl/gpio_pin_array.sv
module gpio_pin_array #(
   parameter int unsigned PINS = 16
) (
   input  logic [PINS-1:0] drive_q,
   input  logic [PINS-1:0] dir_q,
   input  logic [PINS-1:0] pin_in,
   output logic [PINS-1:0] pin_out,
   output logic [PINS-1:0] pin_oe,
   output logic [PINS-1:0] level
);

   for (genvar i = 0; i < PINS; i++) begin : g_pin
      assign pin_out[i] = drive_q[i];
      assign pin_oe[i]  = dir_q[i];
      assign level[i]   = dir_q[i] ? drive_q[i] : pin_in[i];
   end

endmodule

// File: rtl/gpio_apb_port.sv
module gpio_apb_port
   import gpio_apb_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PINS   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic              pwrite,
   input  logic              psel,
   input  logic              penable,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe
);

   localparam int unsigned PAD_W = DATA_W - PINS;

   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("PINS must lie between 1 and DATA_W");
   end
   if (ADDR_W < BYTE_LSB + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for three registers");
   end

   access_t         acc;
   logic [PINS-1:0] drive_q;
   logic [PINS-1:0] dir_q;
   logic [PINS-1:0] level;
   logic [PINS-1:0] rd_sel;

   gpio_apb_decode #(.ADDR_W(ADDR_W)) u_decode (
      .paddr   (paddr),
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .acc     (acc)
   );

   gpio_ctl_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .wdata   (pwdata),
      .drive_q (drive_q),
      .dir_q   (dir_q)
   );

   gpio_pin_array #(.PINS(PINS)) u_pins (
      .drive_q (drive_q),
      .dir_q   (dir_q),
      .pin_in  (pin_in),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .level   (level)
   );

   always_comb begin
      rd_sel = '0;
      if (acc.rd) begin
         case (acc.slot)
            SLOT_DRIVE: rd_sel = drive_q;
            SLOT_DIR:   rd_sel = dir_q;
            SLOT_LEVEL: rd_sel = level;
            default:    rd_sel = '0;
         endcase
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign prdata = {{PAD_W{1'b0}}, rd_sel};
   end else begin : g_nopad
      assign prdata = rd_sel;
   end

   assign pready  = 1'b1;
   assign pslverr = acc.err;

endmodule

// File: rtl/gpio_apb_port_chk.sv
module gpio_apb_port_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PINS   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] pwdata,
   input logic              pwrite,
   input logic              psel,
   input logic              penable,
   input logic [DATA_W-1:0] prdata,
   input logic              pready,
   input logic              pslverr,
   input logic [PINS-1:0]   pin_in,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   assign idx = paddr[ADDR_W-1:2];

   // R7
   a_r7_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
      pready == 1'b1);

   // R9
   a_r9_err_in_access_only: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> (psel && penable));

   a_r9_err_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |=> ($stable(pin_out) && $stable(pin_oe)));

   // R6
   a_r6_no_write_outside_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(psel && penable && pwrite) |=> ($stable(pin_out) && $stable(pin_oe)));

   // R8
   a_r8_upper_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      prdata[DATA_W-1:PINS] == '0);

   // R2
   a_r2_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite && idx == IDX_W'(0))
      |=> pin_out == $past(pwdata[PINS-1:0]));

   // R3
   a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite && idx == IDX_W'(1))
      |=> pin_oe == $past(pwdata[PINS-1:0]));

endmodule

bind gpio_apb_port gpio_apb_port_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .PINS   (PINS)
) u_chk (.*);

// File: tb/gpio_apb_port_bench.sv
module gpio_apb_port_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] paddr;
   logic [31:0] pwdata;
   logic        pwrite;
   logic        psel;
   logic        penable;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;
   logic [15:0] pin_in;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_apb_port u_gpio_apb_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .paddr   (paddr),
      .pwdata  (pwdata),
      .pwrite  (pwrite),
      .psel    (psel),
      .penable (penable),
      .prdata  (prdata),
      .pready  (pready),
      .pslverr (pslverr),
      .pin_in  (pin_in),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );

   typedef struct {
      logic [31:0] rd;
      logic        err;
      string       req;
   } exp_t;

   exp_t        sbq[$];
   int          compared   = 0;
   int          mismatched = 0;
   logic [15:0] m_drive;
   logic [15:0] m_dir;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_pins(input string req);
      @(negedge clk);
      check(req, "pin_out", {16'h0, pin_out}, {16'h0, m_drive});
      check(req, "pin_oe",  {16'h0, pin_oe},  {16'h0, m_dir});
   endtask

   // Monitor: compares every access phase with the scoreboard head.
   always @(negedge clk) begin
      if (rst_n === 1'b1 && psel === 1'b1 && penable === 1'b1) begin
         if (sbq.size() == 0) begin
            check("R6", "unexpected access", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check(e.req, "prdata (R8)", prdata, e.rd);
            check(e.req, "pslverr (R9)", {31'h0, pslverr}, {31'h0, e.err});
            check("R7", "pready", {31'h0, pready}, 32'h1);
         end
      end
   end

   task automatic xfer(input logic wr, input logic [31:0] addr,
                       input logic [31:0] wd, input exp_t e);
      @(posedge clk); #1;
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd;
      @(posedge clk); #1;
      penable = 1'b1;
      sbq.push_back(e);
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic wr_reg(input logic [31:0] addr, input logic [31:0] wd,
                         input string req);
      exp_t        e;
      logic [29:0] idx;
      idx   = addr[31:2];
      e.rd  = 32'h0;
      e.err = (idx >= 30'd2);
      e.req = req;
      xfer(1'b1, addr, wd, e);
      if (idx == 30'd0) m_drive = wd[15:0];
      if (idx == 30'd1) m_dir   = wd[15:0];
   endtask

   task automatic rd_reg(input logic [31:0] addr, input string req);
      exp_t        e;
      logic [29:0] idx;
      idx   = addr[31:2];
      e.err = (idx > 30'd2);
      e.req = req;
      case (idx)
         30'd0:   e.rd = {16'h0, m_drive};
         30'd1:   e.rd = {16'h0, m_dir};
         30'd2:   e.rd = {16'h0, (m_dir & m_drive) | (~m_dir & pin_in)};
         default: e.rd = 32'h0;
      endcase
      xfer(1'b0, addr, 32'hDEAD_BEEF, e);
   endtask

   task automatic summary_and_end();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary_and_end();
   end

   initial begin
      rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      paddr = '0; pwdata = '0; pin_in = 16'h0;
      m_drive = '0; m_dir = '0;
      repeat (3) @(posedge clk);
      // R1: reset state
      @(negedge clk);
      check("R1", "pin_out in reset", {16'h0, pin_out}, 32'h0);
      check("R1", "pin_oe in reset",  {16'h0, pin_oe},  32'h0);
      check("R7", "pready in reset", {31'h0, pready}, 32'h1);
      check("R9", "pslverr idle", {31'h0, pslverr}, 32'h0);
      check("R8", "prdata idle", prdata, 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R2, R4: drive value, upper write bits ignored
      wr_reg(32'h0, 32'hFFFF_ABCD, "R2");
      check_pins("R4");
      rd_reg(32'h0, "R2");

      // R3, R4: direction
      wr_reg(32'h4, 32'h0000_AAAA, "R3");
      check_pins("R3");
      rd_reg(32'h4, "R3");

      // R5: level readback, mixed directions
      pin_in = 16'hFFFF;
      rd_reg(32'h8, "R5");
      pin_in = 16'h1234;
      rd_reg(32'h8, "R5");
      // all outputs, then all inputs
      wr_reg(32'h4, 32'h0000_FFFF, "R3");
      rd_reg(32'h8, "R5");
      wr_reg(32'h4, 32'h0000_0000, "R3");
      pin_in = 16'hC3A5;
      rd_reg(32'h8, "R5");

      // R9: error cases leave state alone
      wr_reg(32'h4, 32'h0000_0F0F, "R3");
      wr_reg(32'h8, 32'h0000_FFFF, "R9");
      check_pins("R9");
      rd_reg(32'hC, "R9");
      wr_reg(32'h10, 32'h0000_1111, "R9");
      check_pins("R9");
      rd_reg(32'h100, "R10");
      wr_reg(32'h8000_0000, 32'h0000_2222, "R10");
      check_pins("R10");

      // R10: byte offset ignored
      wr_reg(32'h5, 32'h0000_00F0, "R10");
      check_pins("R10");
      rd_reg(32'h7, "R10");
      rd_reg(32'h2, "R10");

      // R6: setup phase alone does not write
      @(posedge clk); #1;
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 32'h0; pwdata = 32'h5A5A;
      repeat (3) @(posedge clk); #1;
      psel = 1'b0; pwrite = 1'b0;
      check_pins("R6");
      // R6: enable without select does not write
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b1; pwrite = 1'b1; paddr = 32'h4; pwdata = 32'hFFFF;
      repeat (3) @(posedge clk); #1;
      penable = 1'b0; pwrite = 1'b0;
      check_pins("R6");
      rd_reg(32'h0, "R6");
      rd_reg(32'h4, "R6");

      // R1: asynchronous reset mid-run
      wr_reg(32'h0, 32'h0000_9876, "R2");
      wr_reg(32'h4, 32'h0000_FF00, "R3");
      @(posedge clk); #3;
      rst_n = 1'b0;
      #1;
      m_drive = '0; m_dir = '0;
      check("R1", "pin_out async", {16'h0, pin_out}, 32'h0);
      check("R1", "pin_oe async",  {16'h0, pin_oe},  32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      rd_reg(32'h0, "R1");
      rd_reg(32'h4, "R1");

      repeat (2) @(posedge clk);
      check("R6", "scoreboard drained", sbq.size(), 32'h0);
      summary_and_end();
   end

endmodule